// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading translation entries from memory. A walk starts at a context table whose base and slot come from two configuration inputs. From there it descends through as many as three levels of tables, and the walk may end at any of them, so a mapping covers 16 MB, 256 KB or 4 KB. When the final entry is a valid leaf, the block returns the physical address, the level at which the walk ended and the leaf's three-bit permission field. When the walk meets a malformed entry, it returns an error code instead.

If the leaf's referenced flag is clear, the block writes the entry back to the same memory word with that flag set before it answers. It also does this when the access is a write and the leaf's modified flag is clear, and in that case it sets the modified flag too. When translation is switched off, the virtual address passes straight through and no memory access is made. Permission checking, caching of translations and fault capture are left to the surrounding logic.

Top module: `pgwalk_top`

## Requirements
- R1: With `cfg_enable` low, a request produces a response with `rsp_bypass`=1 (read and write both allowed), `rsp_err`=0, `rsp_level`=0 and `rsp_paddr` equal to the virtual address, and no memory access.
- R2: The first memory read of a walk is at `(cfg_ctx_ptr << 4) + (cfg_ctx_num << 4)`.
- R3: An entry's type is its bits 1:0 (0 invalid, 1 directory, 2 leaf, 3 reserved). After a directory entry D read at level L, the next read is at `((D & ~3) << 4) + 4*index`, where the index is VA[31:24] for level 1, VA[23:18] for level 2 and VA[17:12] for level 3. The context entry counts as level 0.
- R4: A leaf at level 1, 2 or 3 gives `rsp_paddr = (leaf[31:8] << 12) + VA[23:0]`, `+ VA[17:0]` or `+ VA[11:0]` respectively, truncated to the physical width.
- R5: An invalid entry at any level ends the walk with `rsp_err`=1.
- R6: A reserved entry at any level, a leaf in the context table, or a directory entry at level 3 ends the walk with `rsp_err`=4. No other error code appears.
- R7: When the leaf's referenced bit (bit 5) is clear, or the access is a write and its modified bit (bit 6) is clear, the leaf is written back to its own address. The written value has bit 5 set, and bit 6 set as well for a write, with all other bits unchanged.
- R8: When no update is needed, there is no memory write, and a walk that ends in an error never writes.
- R9: The memory request (valid, address, write flag, write data) stays unchanged until `mem_ready` accepts it. A read takes its data in the accepting cycle, and the walk reads exactly one word per level visited.
- R10: On success, `rsp_level` is the level of the leaf (1 to 3) and `rsp_perm` is leaf bits 4:2.
- R11: `req_ready` is high only while idle. Each accepted request gives exactly one single-cycle `rsp_valid` pulse, after which the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| cfg_enable | input | 1 | Translation on; low selects pass-through |
| cfg_ctx_ptr | input | 32 | Context table base, in 16-byte units |
| cfg_ctx_num | input | CTX_W | Context slot number |
| mem_valid | output | 1 | Memory word access requested |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_write | output | 1 | Access is a write-back |
| mem_addr | output | PA_W | Byte address of the word |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Read data, valid in the accepting cycle |
| rsp_valid | output | 1 | Single-cycle response strobe |
| rsp_bypass | output | 1 | Pass-through response, read and write allowed |
| rsp_err | output | 3 | 0 success, 1 invalid entry, 4 malformed walk |
| rsp_level | output | 2 | Level of the leaf, 0 when none |
| rsp_perm | output | 3 | Permission field of the leaf |
| rsp_paddr | output | PA_W | Physical address |

## Verification
The bench builds the block with `CTX_W`=4 and the default 36-bit physical width. This lets it place the context entry in any of the 16 slots and compare the full, untruncated products of the `<< 4` and `<< 12` address arithmetic. For every walk length from zero to three levels, the bench plants each entry type at the level where the walk stops and drives both reads and writes with all four referenced/modified combinations, over several pseudo-random virtual addresses. It then compares every read address, the write-back word and the response against values it computes itself. A memory that refuses one cycle in three keeps requests waiting, so the hold rule is exercised on every walk.

// File: rtl/pgwalk_pkg.sv
// Shared definitions for the page table walker: entry type encoding,
// walker states, error codes, entry bit positions and per-level index fields.
package pgwalk_pkg;

    localparam int DW = 32;
    localparam int VA_W = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int PPN_LO = 8;
    localparam int REF_BIT = 5;
    localparam int MOD_BIT = 6;
    localparam int PERM_LO = 2;
    localparam int PERM_HI = 4;
    localparam int TOP_LVL = 3;

    // Virtual address field that indexes the table of each level (index 0 unused).
    localparam int LVL_IDX_HI [4] = '{0, 31, 23, 17};
    localparam int LVL_IDX_LO [4] = '{0, 24, 18, 12};

    typedef enum logic [1:0] {
        ET_INVALID = 2'd0,
        ET_DIR     = 2'd1,
        ET_LEAF    = 2'd2,
        ET_RSVD    = 2'd3
    } etype_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_READ,
        S_WB,
        S_RESP
    } wstate_e;

    localparam logic [2:0] ERR_NONE    = 3'd0;
    localparam logic [2:0] ERR_INVALID = 3'd1;
    localparam logic [2:0] ERR_STRUCT  = 3'd4;

endpackage

// File: rtl/pgwalk_addr.sv
// Address arithmetic for the walker: root entry address, next-table entry
// address for each level, and the leaf-to-physical address per page size.
// Purely combinational. Assumes PA_W is at least 36 so that no shifted
// term is truncated.
module pgwalk_addr
    import pgwalk_pkg::*;
#(
    parameter int PA_W  = 36,
    parameter int CTX_W = 8
) (
    input  logic [VA_W-1:0]     va,
    input  logic [DW-1:0]       ctx_ptr,
    input  logic [CTX_W-1:0]    ctx_num,
    input  logic [DW-3:0]       desc_hi,
    input  logic [1:0]          dst_lvl,
    input  logic [DW-PPN_LO-1:0] leaf_ppn,
    input  logic [1:0]          leaf_lvl,
    output logic [PA_W-1:0]     root_ptr,
    output logic [PA_W-1:0]     next_ptr,
    output logic [PA_W-1:0]     leaf_pa
);

    logic [PA_W-1:0] tbl_base;
    logic [PA_W-1:0] page_base;
    logic [PA_W-1:0] tbl_ptr [1:TOP_LVL];
    logic [PA_W-1:0] lvl_pa  [1:TOP_LVL];

    // Root entry: base and slot are both in 16-byte units.
    assign root_ptr  = PA_W'({ctx_ptr, 4'b0000}) + PA_W'({ctx_num, 4'b0000});
    // Table base of a directory entry: its pointer field in 16-byte units.
    assign tbl_base  = PA_W'({desc_hi, 6'b000000});
    // Page base of a leaf: its page number field in 4 KB units.
    assign page_base = PA_W'({leaf_ppn, 12'h000});

    // Per-level index field and page offset width.
    for (genvar k = 1; k <= TOP_LVL; k++) begin : g_lvl
        localparam int HI = LVL_IDX_HI[k];
        localparam int LO = LVL_IDX_LO[k];
        assign tbl_ptr[k] = tbl_base + PA_W'({va[HI:LO], 2'b00});
        assign lvl_pa[k]  = page_base + PA_W'(va[LO-1:0]);
    end

    // Pick the next entry address for the level about to be read.
    always_comb begin
        case (dst_lvl)
            2'd1:    next_ptr = tbl_ptr[1];
            2'd2:    next_ptr = tbl_ptr[2];
            2'd3:    next_ptr = tbl_ptr[3];
            default: next_ptr = '0;
        endcase
    end

    // Pick the physical address for the level where the leaf was found.
    always_comb begin
        case (leaf_lvl)
            2'd1:    leaf_pa = lvl_pa[1];
            2'd2:    leaf_pa = lvl_pa[2];
            2'd3:    leaf_pa = lvl_pa[3];
            default: leaf_pa = '0;
        endcase
    end

endmodule

// File: rtl/pgwalk_ctrl.sv
// Walk sequencer: accepts a request, reads one entry per level over a
// single-outstanding word port, decodes entry types, performs the
// referenced/modified write-back and issues a one-cycle response.
// Assumes mem_rdata is valid in the cycle mem_ready accepts a read.
module pgwalk_ctrl
    import pgwalk_pkg::*;
#(
    parameter int PA_W = 36
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               req_write,
    input  logic               cfg_enable,
    input  logic [PA_W-1:0]    root_ptr,
    input  logic [PA_W-1:0]    next_ptr,
    input  logic [PA_W-1:0]    leaf_pa,
    output logic [VA_W-1:0]    va_q,
    output logic [1:0]         dst_lvl,
    output logic [DW-1:0]      entry_q,
    output logic [1:0]         lvl_q,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic               mem_write,
    output logic [PA_W-1:0]    mem_addr,
    output logic [DW-1:0]      mem_wdata,
    input  logic [DW-1:0]      mem_rdata,
    output logic               rsp_valid,
    output logic               rsp_bypass,
    output logic [2:0]         rsp_err,
    output logic [1:0]         rsp_level,
    output logic [2:0]         rsp_perm,
    output logic [PA_W-1:0]    rsp_paddr
);

    wstate_e         state;
    logic [PA_W-1:0] ptr_q;
    logic            wr_q;
    logic            bypass_q;
    logic [2:0]      err_q;
    logic            need_wb;
    logic [DW-1:0]   upd_entry;

    // Level whose table the next read indexes.
    assign dst_lvl = lvl_q + 2'd1;

    // Update rule for a leaf just read: referenced always, modified on write.
    assign need_wb   = !mem_rdata[REF_BIT] || (wr_q && !mem_rdata[MOD_BIT]);
    always_comb begin
        upd_entry          = mem_rdata;
        upd_entry[REF_BIT] = 1'b1;
        upd_entry[MOD_BIT] = mem_rdata[MOD_BIT] | wr_q;
    end

    // Walk state machine and captured request/entry state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            ptr_q    <= '0;
            va_q     <= '0;
            wr_q     <= 1'b0;
            bypass_q <= 1'b0;
            err_q    <= ERR_NONE;
            lvl_q    <= 2'd0;
            entry_q  <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        va_q     <= req_vaddr;
                        wr_q     <= req_write;
                        err_q    <= ERR_NONE;
                        lvl_q    <= 2'd0;
                        bypass_q <= !cfg_enable;
                        ptr_q    <= root_ptr;
                        state    <= cfg_enable ? S_READ : S_RESP;
                    end
                end
                S_READ: begin
                    if (mem_ready) begin
                        case (etype_e'(mem_rdata[1:0]))
                            ET_INVALID: begin
                                err_q <= ERR_INVALID;
                                state <= S_RESP;
                            end
                            ET_RSVD: begin
                                err_q <= ERR_STRUCT;
                                state <= S_RESP;
                            end
                            ET_DIR: begin
                                if (lvl_q == 2'(TOP_LVL)) begin
                                    err_q <= ERR_STRUCT;
                                    state <= S_RESP;
                                end else begin
                                    ptr_q <= next_ptr;
                                    lvl_q <= dst_lvl;
                                end
                            end
                            default: begin
                                if (lvl_q == 2'd0) begin
                                    err_q <= ERR_STRUCT;
                                    state <= S_RESP;
                                end else begin
                                    entry_q <= upd_entry;
                                    state   <= need_wb ? S_WB : S_RESP;
                                end
                            end
                        endcase
                    end
                end
                S_WB: begin
                    if (mem_ready) state <= S_RESP;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Memory port driven straight from registered state.
    assign mem_valid = (state == S_READ) || (state == S_WB);
    assign mem_write = (state == S_WB);
    assign mem_addr  = ptr_q;
    assign mem_wdata = entry_q;

    // Response outputs, masked when no leaf applies.
    assign req_ready  = (state == S_IDLE);
    assign rsp_valid  = (state == S_RESP);
    assign rsp_bypass = bypass_q;
    assign rsp_err    = err_q;
    assign rsp_level  = (bypass_q || err_q != ERR_NONE) ? 2'd0 : lvl_q;
    assign rsp_perm   = (bypass_q || err_q != ERR_NONE) ? 3'd0 : entry_q[PERM_HI:PERM_LO];
    assign rsp_paddr  = bypass_q ? PA_W'(va_q) : ((err_q != ERR_NONE) ? '0 : leaf_pa);

    assert_hold_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_write) && $stable(mem_wdata)));

    assert_bypass_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !cfg_enable) |=> (!mem_valid && rsp_valid && rsp_bypass));

    assert_err_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_err == ERR_NONE || rsp_err == ERR_INVALID || rsp_err == ERR_STRUCT));

    assert_wb_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write) |-> (mem_wdata[REF_BIT] && mem_wdata[1:0] == ET_LEAF));

    assert_single_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    assert_ok_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err == ERR_NONE && !rsp_bypass) |-> (rsp_level != 2'd0));

endmodule

// File: rtl/pgwalk_top.sv
// Top of the page table walker: joins the walk sequencer to the address
// arithmetic. One translation in flight at a time.
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int PA_W  = 36,
    parameter int CTX_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [31:0]        req_vaddr,
    input  logic               req_write,
    input  logic               cfg_enable,
    input  logic [31:0]        cfg_ctx_ptr,
    input  logic [CTX_W-1:0]   cfg_ctx_num,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic               mem_write,
    output logic [PA_W-1:0]    mem_addr,
    output logic [31:0]        mem_wdata,
    input  logic [31:0]        mem_rdata,
    output logic               rsp_valid,
    output logic               rsp_bypass,
    output logic [2:0]         rsp_err,
    output logic [1:0]         rsp_level,
    output logic [2:0]         rsp_perm,
    output logic [PA_W-1:0]    rsp_paddr
);

    logic [PA_W-1:0] root_ptr;
    logic [PA_W-1:0] next_ptr;
    logic [PA_W-1:0] leaf_pa;
    logic [VA_W-1:0] va_q;
    logic [1:0]      dst_lvl;
    logic [1:0]      lvl_q;
    logic [DW-1:0]   entry_q;

    pgwalk_addr #(.PA_W(PA_W), .CTX_W(CTX_W)) u_addr (
        .va       (va_q),
        .ctx_ptr  (cfg_ctx_ptr),
        .ctx_num  (cfg_ctx_num),
        .desc_hi  (mem_rdata[DW-1:2]),
        .dst_lvl  (dst_lvl),
        .leaf_ppn (entry_q[DW-1:PPN_LO]),
        .leaf_lvl (lvl_q),
        .root_ptr (root_ptr),
        .next_ptr (next_ptr),
        .leaf_pa  (leaf_pa)
    );

    pgwalk_ctrl #(.PA_W(PA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_vaddr  (req_vaddr),
        .req_write  (req_write),
        .cfg_enable (cfg_enable),
        .root_ptr   (root_ptr),
        .next_ptr   (next_ptr),
        .leaf_pa    (leaf_pa),
        .va_q       (va_q),
        .dst_lvl    (dst_lvl),
        .entry_q    (entry_q),
        .lvl_q      (lvl_q),
        .mem_valid  (mem_valid),
        .mem_ready  (mem_ready),
        .mem_write  (mem_write),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_bypass (rsp_bypass),
        .rsp_err    (rsp_err),
        .rsp_level  (rsp_level),
        .rsp_perm   (rsp_perm),
        .rsp_paddr  (rsp_paddr)
    );

endmodule

// File: tb/tb_pgwalk_top.sv
// Sweep bench for the page table walker: plants walks ending at every
// level with every entry type and flag combination, then checks the
// memory traffic and the response against arithmetic expectations.
module tb_pgwalk_top;

    localparam int PA_W  = 36;
    localparam int CTX_W = 4;
    localparam logic [35:0] T1 = 36'h0_0004_0000;
    localparam logic [35:0] T2 = 36'h0_0008_0000;
    localparam logic [35:0] T3 = 36'h0_000C_0000;
    localparam logic [31:0] CTXP = 32'h0000_0100;

    logic              clk;
    logic              rst_n;
    logic              req_valid;
    logic              req_ready;
    logic [31:0]       req_vaddr;
    logic              req_write;
    logic              cfg_enable;
    logic [31:0]       cfg_ctx_ptr;
    logic [CTX_W-1:0]  cfg_ctx_num;
    logic              mem_valid;
    logic              mem_ready;
    logic              mem_write;
    logic [PA_W-1:0]   mem_addr;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata;
    logic              rsp_valid;
    logic              rsp_bypass;
    logic [2:0]        rsp_err;
    logic [1:0]        rsp_level;
    logic [2:0]        rsp_perm;
    logic [PA_W-1:0]   rsp_paddr;

    logic [31:0] mem_model [logic [35:0]];
    logic [35:0] rd_log [$];
    logic [35:0] wr_log [$];
    int n_checks = 0;
    int n_errs   = 0;
    int cyc      = 0;
    logic [31:0] lcg = 32'h1234_5678;
    logic        done = 1'b0;

    pgwalk_top #(.PA_W(PA_W), .CTX_W(CTX_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write),
        .cfg_enable(cfg_enable), .cfg_ctx_ptr(cfg_ctx_ptr), .cfg_ctx_num(cfg_ctx_num),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_bypass(rsp_bypass), .rsp_err(rsp_err),
        .rsp_level(rsp_level), .rsp_perm(rsp_perm), .rsp_paddr(rsp_paddr)
    );

    // 50 MHz clock.
    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Memory model: refuses one cycle in three (exercises R9 holding).
    initial begin
        mem_ready = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_ready = (cyc % 3) != 0;
            mem_rdata = mem_model.exists(mem_addr) ? mem_model[mem_addr] : 32'h0;
            if (rst_n && mem_valid && mem_ready) begin
                if (mem_write) begin
                    mem_model[mem_addr] = mem_wdata;
                    wr_log.push_back(mem_addr);
                end else begin
                    rd_log.push_back(mem_addr);
                end
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    // Issue one request; returns 1 when a response was seen.
    task automatic issue(input logic [31:0] va, input logic wr, output bit got);
        int t;
        rd_log.delete();
        wr_log.delete();
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!rsp_valid && t < 2000) begin
            @(negedge clk);
            t++;
        end
        got = rsp_valid;
        if (!got) chk("R11", "response timeout", 64'd0, 64'd1);
    endtask

    task automatic after_rsp();
        @(negedge clk);
        chk("R11", "single strobe", {63'd0, rsp_valid}, 64'd0);
        chk("R11", "idle again", {63'd0, req_ready}, 64'd1);
    endtask

    task automatic walk_case(input int stop_lvl, input logic [1:0] stop_type,
                             input logic wr, input logic refb, input logic modb);
        logic [31:0] va;
        logic [35:0] addr [4];
        logic [31:0] ent [4];
        logic [23:0] ppn;
        logic [2:0]  perm;
        logic [2:0]  exp_err;
        logic [63:0] exp_pa;
        logic [31:0] exp_mem;
        bit wb;
        bit got;
        int off_w;
        va = rnd();
        ppn = rnd() >> 8;
        perm = rnd() >> 29;
        cfg_ctx_num = CTX_W'(rnd() >> 28);
        mem_model.delete();
        addr[0] = {CTXP, 4'h0} + {28'd0, cfg_ctx_num, 4'h0};
        addr[1] = T1 + {26'd0, va[31:24], 2'b00};
        addr[2] = T2 + {28'd0, va[23:18], 2'b00};
        addr[3] = T3 + {28'd0, va[17:12], 2'b00};
        ent[0] = 32'(T1 >> 4) | 32'd1;
        ent[1] = 32'(T2 >> 4) | 32'd1;
        ent[2] = 32'(T3 >> 4) | 32'd1;
        ent[3] = 32'd0;
        if (stop_type == 2'd2)
            ent[stop_lvl] = {ppn, 1'b0, modb, refb, perm, 2'b10};
        else
            ent[stop_lvl] = {rnd() >> 2} & 32'hFFFF_FFFC | {30'd0, stop_type};
        for (int k = 0; k <= stop_lvl; k++) mem_model[addr[k]] = ent[k];

        if (stop_type == 2'd0) exp_err = 3'd1;
        else if (stop_type == 2'd3) exp_err = 3'd4;
        else if (stop_type == 2'd1) exp_err = 3'd4;
        else if (stop_lvl == 0) exp_err = 3'd4;
        else exp_err = 3'd0;
        wb = (exp_err == 0) && (!refb || (wr && !modb));
        off_w = (stop_lvl == 1) ? 24 : (stop_lvl == 2) ? 18 : 12;
        exp_pa = (({40'd0, ppn} << 12) + ({32'd0, va} & ((64'd1 << off_w) - 1))) & 64'hF_FFFF_FFFF;
        exp_mem = ent[stop_lvl];
        if (wb) exp_mem = exp_mem | 32'h20 | (wr ? 32'h40 : 32'h0);

        issue(va, wr, got);
        if (!got) return;
        if (exp_err == 3'd1) chk("R5", "invalid code", {61'd0, rsp_err}, {61'd0, exp_err});
        else chk("R6", "error code", {61'd0, rsp_err}, {61'd0, exp_err});
        chk("R9", "read count", 64'(rd_log.size()), 64'(stop_lvl + 1));
        if (rd_log.size() > 0) chk("R2", "root address", {28'd0, rd_log[0]}, {28'd0, addr[0]});
        for (int k = 1; k <= stop_lvl && k < rd_log.size(); k++)
            chk("R3", "level address", {28'd0, rd_log[k]}, {28'd0, addr[k]});
        chk("R1", "bypass flag off", {63'd0, rsp_bypass}, 64'd0);
        if (exp_err == 0) begin
            chk("R4", "physical address", {28'd0, rsp_paddr}, exp_pa);
            chk("R10", "level", {62'd0, rsp_level}, 64'(stop_lvl));
            chk("R10", "perm", {61'd0, rsp_perm}, {61'd0, perm});
        end
        if (wb) begin
            chk("R7", "write count", 64'(wr_log.size()), 64'd1);
            if (wr_log.size() > 0) chk("R7", "write address", {28'd0, wr_log[0]}, {28'd0, addr[stop_lvl]});
            chk("R7", "written entry", {32'd0, mem_model[addr[stop_lvl]]}, {32'd0, exp_mem});
        end else begin
            chk("R8", "no write", 64'(wr_log.size()), 64'd0);
            chk("R8", "entry unchanged", {32'd0, mem_model[addr[stop_lvl]]}, {32'd0, exp_mem});
        end
        after_rsp();
    endtask

    task automatic bypass_case(input logic [31:0] va, input logic wr);
        bit got;
        cfg_enable = 1'b0;
        issue(va, wr, got);
        if (got) begin
            chk("R1", "bypass flag", {63'd0, rsp_bypass}, 64'd1);
            chk("R1", "bypass address", {28'd0, rsp_paddr}, {32'd0, va});
            chk("R1", "bypass error", {61'd0, rsp_err}, 64'd0);
            chk("R1", "bypass level", {62'd0, rsp_level}, 64'd0);
            chk("R1", "no memory traffic", 64'(rd_log.size() + wr_log.size()), 64'd0);
            after_rsp();
        end
        cfg_enable = 1'b1;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(200000 * 20);
        if (!done) begin
            n_errs++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_vaddr = '0;
        req_write = 1'b0;
        cfg_enable = 1'b1;
        cfg_ctx_ptr = CTXP;
        cfg_ctx_num = '0;
        repeat (3) @(negedge clk);
        chk("R11", "reset ready", {63'd0, req_ready}, 64'd1);
        chk("R11", "reset no response", {63'd0, rsp_valid}, 64'd0);
        chk("R9", "reset no access", {63'd0, mem_valid}, 64'd0);
        rst_n = 1'b1;

        bypass_case(32'h0000_0000, 1'b0);
        bypass_case(32'hFFFF_FFFF, 1'b1);
        bypass_case(32'hDEAD_BEEF, 1'b0);

        for (int rep = 0; rep < 3; rep++)
            for (int lv = 0; lv <= 3; lv++)
                for (int ty = 0; ty < 4; ty++) begin
                    if (ty == 1 && lv < 3) continue;
                    for (int w = 0; w < 2; w++)
                        for (int rm = 0; rm < 4; rm++)
                            walk_case(lv, 2'(ty), w[0], rm[0], rm[1]);
                end

        bypass_case(32'h1234_5678, 1'b1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

endmodule